// File: doc/BRIEF.md
# Vectored Interrupt Controller with Two-Level Masking

This block collects twenty interrupt request lines and, whenever the processor signals that an instruction has just completed, picks one pending source and hands back the 16-bit address of its service-routine vector. Line 0 is a non-maskable request. It is gated only by its own mask bit X. Lines 1 to 19 are maskable. Each of them has an arm bit, and all of them are gated by a common mask bit I. The five lowest-priority lines are serial-port causes that share a single vector, so the service routine has to poll to find out which one fired.

Priority is fixed: the lowest index wins. Software can load a promotion register with the index of one maskable source, and that source then ranks above every other maskable source. It always stays below line 0. When a request is taken, the controller saves the current mask bits in a small last-in-first-out store and then raises the masks. A return strobe restores the saved values. Software can clear X but has no way of setting it. I can be written in both directions.

The controller presents its result as a one-cycle acknowledge pulse, registered one clock after the accepting boundary, together with the vector address and the winning source index. Stacking registers, fetching the vector contents and the peripherals' own flag logic all live outside this block.

Top module: `irq_vector_ctl`

## Requirements
- R1: While rst is high and after it is released: x_mask_o=1, i_mask_o=1, the promotion register is 0, vec_valid_o=0, vec_addr_o=0 and vec_src_o=0.
- R2: Source index k selects vector 0xFFF4 minus 2*k for k in 0..14, so index 0 gives 0xFFF4, index 1 gives 0xFFF2 and index 14 gives 0xFFD8. Indices 15 to 19 all share vector 0xFFD6. On a taken request, vec_valid_o pulses for one cycle, and vec_addr_o and vec_src_o carry the winner in that same cycle. They read 0 whenever vec_valid_o is 0.
- R3: A maskable source k (1..19) is eligible only when req_i[k]=1, arm_i[k]=1 and I=0. Source 0 is eligible when req_i[0]=1 and X=0. It has no arm bit and I does not gate it.
- R4: A request is taken only on a clock edge where boundary_i=1 and ret_i=0 and some source is eligible. vec_valid_o is 1 in the cycle after that edge and at no other time.
- R5: Among eligible sources with the promotion register inactive, the lowest index wins.
- R6: When prio_we_i=1, prio_wdata_i is loaded into the promotion register. If that register holds a value p in 1..19 and source p is eligible, p wins over all other maskable sources. Source 0 still wins over p. Values 0 and 20..31 leave the order of R5 in place.
- R7: Taking any request sets I to 1. Taking source 0 also sets X to 1. Both take effect in the same cycle that vec_valid_o is 1.
- R8: x_clr_i=1 clears X. Nothing except reset and taking source 0 can set X, and a return never sets it: the value after a return is the current X AND the saved X.
- R9: Each taken request saves {X,I}, nesting up to SAVE_DEPTH deep. ret_i=1 pops the latest saved pair and restores it (subject to R8). A return with nothing saved leaves both masks unchanged.
- R10: Within one cycle, taking a request overrides a software write to I. A return strobe overrides both x_clr_i and a write to I, even when nothing is saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 20 | Request lines; bit 0 is the non-maskable line |
| arm_i | input | 19 | Arm bits for maskable lines 1..19 (bit k arms line k) |
| boundary_i | input | 1 | Instruction-completed strobe |
| ret_i | input | 1 | Return-from-service strobe |
| i_wr_i | input | 1 | Software write enable for I |
| i_wdata_i | input | 1 | Value written to I |
| x_clr_i | input | 1 | Software clear of X |
| prio_we_i | input | 1 | Promotion register write enable |
| prio_wdata_i | input | 5 | Index of the source to promote |
| vec_valid_o | output | 1 | Acknowledge pulse |
| vec_addr_o | output | 16 | Vector address of the winner |
| vec_src_o | output | 5 | Index of the winner |
| x_mask_o | output | 1 | Current X mask bit |
| i_mask_o | output | 1 | Current I mask bit |

## Verification
The bench sweeps every single source and every ordered pair of maskable sources, once with both armed and once with the higher-priority one disarmed. A design that mixes up its priority direction or ignores arm bits would return the wrong index. Every promotion value from 0 to 31 is tried with all maskable lines requesting; a decoder that wraps out-of-range indices or treats 0 as a source would pick the wrong winner. The shared serial vector, X being masked at reset, nesting of a non-maskable entry inside a maskable one, and a return after a software clear of X are all exercised; a design that restores X blindly would bring back a masked non-maskable line. The bench also covers same-cycle collisions of entry, return and software writes, and a return with nothing saved; a design with the precedence wrong would leave I in the wrong state.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int VEC_W = 16;
  typedef logic [VEC_W-1:0] vec_t;

  // Vector for a source: descending by two per index, clamped at the shared slot.
  function automatic vec_t vec_for(input int unsigned idx,
                                   input int unsigned shared_first,
                                   input vec_t top);
    int unsigned eff;
    eff = (idx >= shared_first) ? shared_first : idx;
    return top - VEC_W'(2 * eff);
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 20,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:1] arm,
  input  logic            x_mask,
  input  logic            i_mask,
  input  logic [IDXW-1:0] prio,
  output logic            any_o,
  output logic [IDXW-1:0] win_o
);
  localparam int NPOW = 1 << IDXW;
  localparam logic [IDXW:0] NSRC_W = NSRC[IDXW:0];

  logic [NSRC-1:0] elig;
  logic [NPOW-1:0] elig_w;
  logic [IDXW-1:0] first;
  logic            promo_ok;

  // eligibility per line: line 0 gated by X only, others by arm and I
  assign elig[0] = req[0] & ~x_mask;
  for (genvar k = 1; k < NSRC; k++) begin : g_elig
    assign elig[k] = req[k] & arm[k] & ~i_mask;
  end

  assign elig_w = NPOW'(elig);

  // lowest eligible maskable index
  always_comb begin
    first = '0;
    for (int k = NSRC - 1; k >= 1; k--) begin
      if (elig[k]) first = IDXW'(k);
    end
  end

  assign promo_ok = (prio != '0) && ({1'b0, prio} < NSRC_W) && elig_w[prio];
  assign any_o    = |elig;

  always_comb begin
    if (elig[0])       win_o = '0;
    else if (promo_ok) win_o = prio;
    else               win_o = first;
  end

  // R5/R6: any selected winner must itself be eligible
  a_r5_win_eligible: assert property (@(posedge clk) disable iff (rst)
    any_o |-> elig_w[win_o]);
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty_o,
  output logic [W-1:0] top_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  // a full store overwrites its newest entry
  assign wr_idx  = (cnt == FULL) ? AW'(DEPTH - 1) : AW'(cnt);
  assign rd_idx  = AW'(cnt - PW'(1));
  assign empty_o = (cnt == '0);
  assign top_o   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push) begin
      if (cnt != FULL) cnt <= cnt + PW'(1);
    end else if (pop && cnt != '0) begin
      cnt <= cnt - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  a_r9_no_push_pop: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int SAVE_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_nmi,
  input  logic ret,
  input  logic i_wr,
  input  logic i_wdata,
  input  logic x_clr,
  output logic x_o,
  output logic i_o
);
  logic       empty;
  logic [1:0] saved;
  logic       pop;

  assign pop = ret & ~take & ~empty;

  irq_save_stack #(.DEPTH(SAVE_DEPTH), .W(2)) u_save (
    .clk       (clk),
    .rst       (rst),
    .push      (take),
    .push_data ({x_o, i_o}),
    .pop       (pop),
    .empty_o   (empty),
    .top_o     (saved)
  );

  // precedence: entry, then return, then software writes
  always_ff @(posedge clk) begin
    if (rst) begin
      x_o <= 1'b1;
      i_o <= 1'b1;
    end else if (take) begin
      if (take_nmi) x_o <= 1'b1;
      i_o <= 1'b1;
    end else if (ret) begin
      if (!empty) begin
        x_o <= x_o & saved[1];
        i_o <= saved[0];
      end
    end else begin
      if (x_clr) x_o <= 1'b0;
      if (i_wr)  i_o <= i_wdata;
    end
  end

  // R8: X rises only on a taken non-maskable request
  a_r8_x_rise_only_nmi: assert property (@(posedge clk) disable iff (rst)
    $rose(x_o) |-> $past(take && take_nmi));
  // R7: entry leaves I set
  a_r7_take_sets_i: assert property (@(posedge clk) disable iff (rst)
    take |=> i_o);
  // R9: empty return changes nothing
  a_r9_empty_ret_stable: assert property (@(posedge clk) disable iff (rst)
    (ret && empty && !take) |=> ($stable(x_o) && $stable(i_o)));
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int                  NSRC         = 20,
  parameter int                  SHARED_FIRST = 15,
  parameter int                  SAVE_DEPTH   = 4,
  parameter logic [15:0]         TOP_VEC      = 16'hFFF4,
  parameter int                  IDXW         = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:1] arm_i,
  input  logic            boundary_i,
  input  logic            ret_i,
  input  logic            i_wr_i,
  input  logic            i_wdata_i,
  input  logic            x_clr_i,
  input  logic            prio_we_i,
  input  logic [IDXW-1:0] prio_wdata_i,
  output logic            vec_valid_o,
  output logic [15:0]     vec_addr_o,
  output logic [IDXW-1:0] vec_src_o,
  output logic            x_mask_o,
  output logic            i_mask_o
);
  import irq_vec_pkg::*;

  logic [IDXW-1:0] prio_q;
  logic            any;
  logic [IDXW-1:0] win;
  logic            take;
  logic            take_nmi;

  always_ff @(posedge clk) begin
    if (rst)            prio_q <= '0;
    else if (prio_we_i) prio_q <= prio_wdata_i;
  end

  irq_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .req    (req_i),
    .arm    (arm_i),
    .x_mask (x_mask_o),
    .i_mask (i_mask_o),
    .prio   (prio_q),
    .any_o  (any),
    .win_o  (win)
  );

  assign take     = boundary_i & ~ret_i & any;
  assign take_nmi = (win == '0);

  irq_mask_unit #(.SAVE_DEPTH(SAVE_DEPTH)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_nmi (take_nmi),
    .ret      (ret_i),
    .i_wr     (i_wr_i),
    .i_wdata  (i_wdata_i),
    .x_clr    (x_clr_i),
    .x_o      (x_mask_o),
    .i_o      (i_mask_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid_o <= 1'b0;
      vec_addr_o  <= '0;
      vec_src_o   <= '0;
    end else begin
      vec_valid_o <= take;
      vec_addr_o  <= take ? vec_for(int'(win), SHARED_FIRST, TOP_VEC) : '0;
      vec_src_o   <= take ? win : '0;
    end
  end

  // R4: acknowledge only after an accepting boundary
  a_r4_ack_after_boundary: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(boundary_i && !ret_i));
  // R6: an unmasked non-maskable request always wins
  a_r6_nmi_first: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && $past(req_i[0] && !x_mask_o)) |-> (vec_src_o == '0));
  // R3: a maskable winner was armed
  a_r3_winner_armed: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && vec_src_o != '0) |-> ((({$past(arm_i), 1'b0} >> vec_src_o) & 1) != 0));
endmodule

// File: tb/irq_vector_ctl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctl_tb;
  localparam int NSRC = 20;
  localparam int IDXW = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] req_i;
  logic [NSRC-1:1] arm_i;
  logic            boundary_i, ret_i, i_wr_i, i_wdata_i, x_clr_i, prio_we_i;
  logic [IDXW-1:0] prio_wdata_i;
  logic            vec_valid_o;
  logic [15:0]     vec_addr_o;
  logic [IDXW-1:0] vec_src_o;
  logic            x_mask_o, i_mask_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  irq_vector_ctl u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .arm_i(arm_i),
    .boundary_i(boundary_i), .ret_i(ret_i), .i_wr_i(i_wr_i),
    .i_wdata_i(i_wdata_i), .x_clr_i(x_clr_i), .prio_we_i(prio_we_i),
    .prio_wdata_i(prio_wdata_i), .vec_valid_o(vec_valid_o),
    .vec_addr_o(vec_addr_o), .vec_src_o(vec_src_o),
    .x_mask_o(x_mask_o), .i_mask_o(i_mask_o)
  );

  always #4 clk = ~clk;

  function automatic int exp_vec(input int idx);
    if (idx == 0) return 'hFFF4;
    if (idx >= 15) return 'hFFD6;
    return 'hFFF4 - 2 * idx;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_i = '0; arm_i = '0; boundary_i = 0; ret_i = 0;
    i_wr_i = 0; i_wdata_i = 0; x_clr_i = 0; prio_we_i = 0; prio_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic take(input logic [NSRC-1:0] rq, input logic [NSRC-1:1] am);
    @(negedge clk);
    req_i = rq; arm_i = am; boundary_i = 1;
    @(negedge clk);
    boundary_i = 0; req_i = '0;
  endtask

  task automatic ret_op();
    @(negedge clk); ret_i = 1;
    @(negedge clk); ret_i = 0;
  endtask

  task automatic set_i(input logic v);
    @(negedge clk); i_wr_i = 1; i_wdata_i = v;
    @(negedge clk); i_wr_i = 0;
  endtask

  task automatic set_prio(input int p);
    @(negedge clk); prio_we_i = 1; prio_wdata_i = IDXW'(p);
    @(negedge clk); prio_we_i = 0;
  endtask

  task automatic expect_win(input string tag, input int idx);
    chk({tag, " valid"}, int'(vec_valid_o), 1);
    chk({tag, " src"}, int'(vec_src_o), idx);
    chk({tag, " addr"}, int'(vec_addr_o), exp_vec(idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 x", int'(x_mask_o), 1);
    chk("R1 i", int'(i_mask_o), 1);
    chk("R1 valid", int'(vec_valid_o), 0);
    chk("R1 addr", int'(vec_addr_o), 0);
    chk("R1 src", int'(vec_src_o), 0);

    set_i(0);
    // R4: no boundary, no acknowledge
    @(negedge clk); req_i = '1; arm_i = '1;
    repeat (3) begin
      @(negedge clk);
      chk("R4 no boundary", int'(vec_valid_o), 0);
    end
    req_i = '0;

    // R2 single-source sweep including shared serial vector
    for (int k = 1; k < NSRC; k++) begin
      take(NSRC'(1) << k, '1);
      expect_win("R2 single", k);
      chk("R7 i set", int'(i_mask_o), 1);
      ret_op();
      chk("R9 i restored", int'(i_mask_o), 0);
    end

    // R3: X=1 masks line 0
    take(NSRC'(1), '1);
    chk("R3 nmi masked", int'(vec_valid_o), 0);
    @(negedge clk); x_clr_i = 1;
    @(negedge clk); x_clr_i = 0;
    chk("R8 x cleared", int'(x_mask_o), 0);
    take(NSRC'(1), '0);
    expect_win("R3 nmi", 0);
    chk("R7 nmi x", int'(x_mask_o), 1);
    chk("R7 nmi i", int'(i_mask_o), 1);
    ret_op();
    chk("R9 nmi x back", int'(x_mask_o), 0);
    chk("R9 nmi i back", int'(i_mask_o), 0);

    // R5 pair sweep; R3 with higher one disarmed
    for (int a = 1; a < NSRC; a++) begin
      for (int b = a + 1; b < NSRC; b++) begin
        logic [NSRC-1:0] rq;
        logic [NSRC-1:1] am;
        rq = (NSRC'(1) << a) | (NSRC'(1) << b);
        take(rq, '1);
        chk("R5 pair", int'(vec_src_o), a);
        ret_op();
        am = '1; am[a] = 1'b0;
        take(rq, am);
        chk("R3 disarmed", int'(vec_src_o), b);
        ret_op();
      end
    end

    // R6 promotion sweep over the whole register range
    for (int p = 0; p < 32; p++) begin
      set_prio(p);
      take(NSRC'('hFFFFE), '1);
      chk("R6 promote", int'(vec_src_o), (p >= 1 && p < NSRC) ? p : 1);
      ret_op();
    end
    set_prio(7);
    take('1, '1);
    chk("R6 nmi over promoted", int'(vec_src_o), 0);
    ret_op();
    set_prio(0);

    // R3: I=1 masks maskable lines
    set_i(1);
    take(NSRC'(1) << 4, '1);
    chk("R3 i masks", int'(vec_valid_o), 0);
    set_i(0);

    // R9 nesting
    take(NSRC'(1) << 3, '1);
    expect_win("R9 outer", 3);
    take(NSRC'(1), '1);
    expect_win("R9 inner", 0);
    ret_op();
    chk("R9 nest x", int'(x_mask_o), 0);
    chk("R9 nest i", int'(i_mask_o), 1);
    ret_op();
    chk("R9 unnest i", int'(i_mask_o), 0);

    // R8: return never sets X
    do_reset();
    set_i(0);
    take(NSRC'(1) << 5, '1);
    expect_win("R8 entry", 5);
    @(negedge clk); x_clr_i = 1;
    @(negedge clk); x_clr_i = 0;
    ret_op();
    chk("R8 x stays clear", int'(x_mask_o), 0);
    chk("R8 i restored", int'(i_mask_o), 0);

    // R10/R9: empty return with write to I and clear of X
    do_reset();
    set_i(0);
    @(negedge clk); ret_i = 1; i_wr_i = 1; i_wdata_i = 1; x_clr_i = 1;
    @(negedge clk); ret_i = 0; i_wr_i = 0; x_clr_i = 0;
    chk("R10 ret over write i", int'(i_mask_o), 0);
    chk("R10 ret over clear x", int'(x_mask_o), 1);

    // R10: entry overrides write of I
    @(negedge clk); req_i = NSRC'(1) << 2; arm_i = '1; boundary_i = 1; i_wr_i = 1; i_wdata_i = 0;
    @(negedge clk); req_i = '0; boundary_i = 0; i_wr_i = 0;
    chk("R10 entry valid", int'(vec_valid_o), 1);
    chk("R10 entry over write", int'(i_mask_o), 1);
    ret_op();
    chk("R10 back to 0", int'(i_mask_o), 0);

    // R4: boundary together with return is not accepted
    @(negedge clk); req_i = NSRC'(1) << 2; boundary_i = 1; ret_i = 1;
    @(negedge clk); req_i = '0; boundary_i = 0; ret_i = 0;
    chk("R4 ret blocks", int'(vec_valid_o), 0);
    chk("R4 i unchanged", int'(i_mask_o), 0);
    // R2 pulse is one cycle
    take(NSRC'(1) << 6, '1);
    expect_win("R2 pulse", 6);
    @(negedge clk);
    chk("R2 pulse ends", int'(vec_valid_o), 0);
    chk("R2 addr cleared", int'(vec_addr_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule